// File: doc/BRIEF.md
# SPI Sample-Frame Bridge

A slave-side SPI bridge between an external master and a frame-based transform engine. The serial clock, chip select and data input arrive asynchronously. Each of them passes through a three-stage synchronizer into the system clock. Edges are found by comparing the last two synchronized samples. Serial bits form bytes, most significant bit first (SPI mode 0). Each byte is stored as one audio sample in a frame buffer of `FRAME_LEN` entries.

When the last sample of a frame is stored, the bridge raises a single-cycle start pulse toward the engine. The engine reads the frame through a registered read port, which returns each sample as a 32-bit complex word. The engine writes its 32-bit results into a separate result buffer.

During every chip-select window the bridge also returns results on the data output. It fetches a word, waits one cycle for the buffer read, loads a shift register, and shifts one bit per falling serial clock edge. Samples and results travel at the same time in the same transaction.

Top module: `spi_frame_bridge`

## Requirements
- R1: Input bits are taken on the synchronized rising edge of `sclk_i` while `cs_ni` is low, most significant bit first. Every eighth bit completes a byte, which is written into the next frame-buffer entry.
- R2: `eng_rdata_o` returns the entry at `eng_raddr_i` one clock later. Its bits [31:16] hold the stored byte sign-extended to 16 bits, and bits [15:0] are zero. For example, 8'h80 reads as 32'hFF80_0000.
- R3: `start_o` is high for exactly one clock after the `FRAME_LEN`-th byte of a frame is stored. It is never high while a frame is still incomplete.
- R4: The frame write position returns to entry 0 after each complete frame and carries over across chip-select windows. A stream of k*`FRAME_LEN` bytes therefore gives k start pulses, and the buffer then holds the last frame.
- R5: Raising `cs_ni` clears the bit count. A partial byte is discarded and does not shift the byte alignment of the next window.
- R6: Words written through `eng_we_i`/`eng_waddr_i`/`eng_wdata_i` are returned on `miso_o` most significant bit first, in address order. One bit goes out per rising `sclk_i`, and `miso_o` changes only after a falling edge of `sclk_i`.
- R7: Each new chip-select window starts the return from result address 0.
- R8: `miso_o` is 0 while `cs_ni` is high.
- R9: After reset, `start_o` and `miso_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from master (asynchronous) |
| cs_ni | input | 1 | Chip select, active low (asynchronous) |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| start_o | output | 1 | One-cycle frame-ready pulse to the engine |
| eng_raddr_i | input | AW | Engine read address into the frame buffer |
| eng_rdata_o | output | 32 | Complex sample word, one-cycle latency |
| eng_we_i | input | 1 | Engine result write enable |
| eng_waddr_i | input | AW | Result buffer write address |
| eng_wdata_i | input | 32 | Result word |

## Verification
The hardest case is a single window that pushes several full frames in while results stream out. The write position must wrap several times without disturbing the return order. The stimulus first aborts a window after three bits and then sends one frame, with a behavioural engine that answers it. A second window sends four frames' worth of bytes, enough to clock out every result word. The engine is held off during that window, so the returned words must match the first frame's results. A short third window then checks that the return restarts at address 0 and that a partial frame raises no start.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;
  localparam int SAMPLE_W = 8;
  localparam int HALF_W   = 16;
  localparam int WORD_W   = 2 * HALF_W;

  typedef enum logic [1:0] {TX_IDLE, TX_FETCH, TX_WAIT, TX_SHIFT} tx_state_e;

  function automatic logic [WORD_W-1:0] to_cplx(input logic [SAMPLE_W-1:0] s);
    return {{(HALF_W-SAMPLE_W){s[SAMPLE_W-1]}}, s, {HALF_W{1'b0}}};
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s0, s1, s2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0 <= RST_VAL;
      s1 <= RST_VAL;
      s2 <= RST_VAL;
    end else begin
      s0 <= d_i;
      s1 <= s0;
      s2 <= s1;
    end
  end

  assign lvl_o  = s1;
  assign prev_o = s2;
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
  import spi_bridge_pkg::*;
#(
  parameter int FRAME_LEN = 512,
  localparam int AW = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sclk_rise_i,
  input  logic              mosi_i,
  input  logic [AW-1:0]     eng_raddr_i,
  output logic [WORD_W-1:0] eng_rdata_o,
  output logic              byte_we_o,
  output logic              start_o
);
  localparam int BCW = $clog2(SAMPLE_W);
  localparam logic [BCW-1:0] BC_LAST = BCW'(SAMPLE_W - 1);
  localparam logic [AW-1:0]  WP_LAST = AW'(FRAME_LEN - 1);

  logic [SAMPLE_W-1:0] mem [FRAME_LEN];
  logic [SAMPLE_W-1:0] shreg, byte_q;
  logic [BCW-1:0]      bcnt;
  logic [AW-1:0]       wptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg     <= '0;
      bcnt      <= '0;
      byte_q    <= '0;
      byte_we_o <= 1'b0;
    end else begin
      byte_we_o <= 1'b0;
      if (!cs_act_i) begin
        bcnt <= '0;
      end else if (sclk_rise_i) begin
        shreg <= {shreg[SAMPLE_W-2:0], mosi_i};
        bcnt  <= (bcnt == BC_LAST) ? '0 : bcnt + 1'b1;
        if (bcnt == BC_LAST) begin
          byte_q    <= {shreg[SAMPLE_W-2:0], mosi_i};
          byte_we_o <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr    <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= byte_we_o && (wptr == WP_LAST);
      if (byte_we_o) wptr <= (wptr == WP_LAST) ? '0 : wptr + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (byte_we_o) mem[wptr] <= byte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eng_rdata_o <= '0;
    else         eng_rdata_o <= to_cplx(mem[eng_raddr_i]);
  end
endmodule

// File: rtl/spi_tx_return.sv
module spi_tx_return
  import spi_bridge_pkg::*;
#(
  parameter int FRAME_LEN = 512,
  localparam int AW = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sclk_fall_i,
  input  logic              eng_we_i,
  input  logic [AW-1:0]     eng_waddr_i,
  input  logic [WORD_W-1:0] eng_wdata_i,
  output logic              miso_o,
  output logic              tx_load_o
);
  localparam int BCW = $clog2(WORD_W);
  localparam logic [BCW-1:0] BC_LAST = BCW'(WORD_W - 1);
  localparam logic [AW-1:0]  RP_LAST = AW'(FRAME_LEN - 1);

  logic [WORD_W-1:0] mem [FRAME_LEN];
  logic [WORD_W-1:0] rdata, shreg;
  logic [AW-1:0]     rptr;
  logic [BCW-1:0]    bcnt;
  tx_state_e         state;

  always_ff @(posedge clk_i) begin
    if (eng_we_i) mem[eng_waddr_i] <= eng_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata <= '0;
    else         rdata <= mem[rptr];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= TX_IDLE;
      rptr  <= '0;
      bcnt  <= '0;
      shreg <= '0;
    end else if (!cs_act_i) begin
      state <= TX_IDLE;
      rptr  <= '0;
      bcnt  <= '0;
    end else begin
      unique case (state)
        TX_IDLE:  state <= TX_FETCH;
        TX_FETCH: state <= TX_WAIT;   // read issued at rptr
        TX_WAIT: begin                // read settled, load
          shreg <= rdata;
          state <= TX_SHIFT;
        end
        TX_SHIFT: if (sclk_fall_i) begin
          if (bcnt == BC_LAST) begin
            bcnt  <= '0;
            rptr  <= (rptr == RP_LAST) ? '0 : rptr + 1'b1;
            state <= TX_FETCH;
          end else begin
            bcnt  <= bcnt + 1'b1;
            shreg <= {shreg[WORD_W-2:0], 1'b0};
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign tx_load_o = (state == TX_WAIT);
  assign miso_o    = cs_act_i & shreg[WORD_W-1];
endmodule

// File: rtl/spi_frame_bridge.sv
module spi_frame_bridge
  import spi_bridge_pkg::*;
#(
  parameter int FRAME_LEN = 512,
  localparam int AW = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              start_o,
  input  logic [AW-1:0]     eng_raddr_i,
  output logic [WORD_W-1:0] eng_rdata_o,
  input  logic              eng_we_i,
  input  logic [AW-1:0]     eng_waddr_i,
  input  logic [WORD_W-1:0] eng_wdata_i
);
  logic [2:0] lvl, prev;
  logic       sclk_rise, sclk_fall, cs_act, byte_we, tx_load;

  // bit 2: cs_ni, bit 1: sclk, bit 0: mosi
  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sclk_i, mosi_i}),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  assign sclk_rise = lvl[1] & ~prev[1];
  assign sclk_fall = ~lvl[1] & prev[1];
  assign cs_act    = ~lvl[2];

  spi_rx_frame #(.FRAME_LEN(FRAME_LEN)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_act_i    (cs_act),
    .sclk_rise_i (sclk_rise),
    .mosi_i      (lvl[0]),
    .eng_raddr_i (eng_raddr_i),
    .eng_rdata_o (eng_rdata_o),
    .byte_we_o   (byte_we),
    .start_o     (start_o)
  );

  spi_tx_return #(.FRAME_LEN(FRAME_LEN)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_act_i    (cs_act),
    .sclk_fall_i (sclk_fall),
    .eng_we_i    (eng_we_i),
    .eng_waddr_i (eng_waddr_i),
    .eng_wdata_i (eng_wdata_i),
    .miso_o      (miso_o),
    .tx_load_o   (tx_load)
  );
endmodule

// File: rtl/spi_frame_bridge_chk.sv
module spi_frame_bridge_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic miso_o,
  input logic start_o,
  input logic byte_we,
  input logic sclk_fall,
  input logic tx_load,
  input logic cs_act
);
  a_r3_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  a_r3_start_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(byte_we));

  a_r8_miso_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) |-> !miso_o);

  a_r6_miso_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_act && !sclk_fall && !tx_load |=> !cs_act || $stable(miso_o));
endmodule

bind spi_frame_bridge spi_frame_bridge_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .miso_o    (miso_o),
  .start_o   (start_o),
  .byte_we   (byte_we),
  .sclk_fall (sclk_fall),
  .tx_load   (tx_load),
  .cs_act    (cs_act)
);

// File: tb/tb_spi_frame_bridge.sv
module tb_spi_frame_bridge;
  localparam int N  = 16;
  localparam int AW = $clog2(N);
  localparam int HP = 8;  // sclk half period in clk cycles

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, start;
  logic [AW-1:0] raddr = '0, waddr = '0;
  logic [31:0] rdata, wdata = '0;
  logic we = 1'b0;

  always #5 clk = ~clk;

  spi_frame_bridge #(.FRAME_LEN(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .start_o(start), .eng_raddr_i(raddr), .eng_rdata_o(rdata),
    .eng_we_i(we), .eng_waddr_i(waddr), .eng_wdata_i(wdata));

  int checks = 0, fails = 0;
  int starts = 0, start_hi = 0;
  logic start_d = 1'b0;
  logic stub_en = 1'b0;
  bit   stub_busy = 1'b0;
  logic [31:0] exp_in[$];
  logic [31:0] exp_out[$];
  logic [31:0] saved[N];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cplx(input logic [7:0] b);
    return {{8{b[7]}}, b, 16'h0000};
  endfunction

  function automatic logic [31:0] res_of(input logic [31:0] w, input int i);
    return {w[31:16] ^ 16'h5A3C, 16'(i) ^ 16'h0F00};
  endfunction

  always @(posedge clk) begin
    start_d <= start;
    if (start) start_hi <= start_hi + 1;
    if (start && !start_d) starts <= starts + 1;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input logic b, output logic r);
    mosi = b;
    wait_clk(HP);
    r = miso;
    sclk = 1'b1;
    wait_clk(HP);
    sclk = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      spi_bit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cs_on;
    cs_n = 1'b0;
    wait_clk(2*HP);
  endtask

  task automatic cs_off;
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(2*HP);
  endtask

  function automatic logic [7:0] pat_b(input int i);
    case (i)
      0: return 8'h80;
      1: return 8'hFF;
      2: return 8'h7F;
      3: return 8'h00;
      default: return 8'((i * 37) ^ 8'h5C);
    endcase
  endfunction

  // behavioural engine stub: reads frame, checks words, writes results
  initial begin
    forever begin
      @(negedge clk);
      if (start && stub_en) begin
        stub_busy = 1'b1;
        for (int i = 0; i < N; i++) begin
          logic [31:0] e;
          raddr = AW'(i);
          we = 1'b0;
          @(posedge clk);
          @(negedge clk);
          e = (exp_in.size() > 0) ? exp_in.pop_front() : 32'hDEAD_BEEF;
          chk(rdata === e, $sformatf("R2 word %0d", i), rdata, e);
          we = 1'b1;
          waddr = AW'(i);
          wdata = res_of(rdata, i);
          exp_out.push_back(res_of(e, i));
          saved[i] = res_of(e, i);
          @(negedge clk);
          we = 1'b0;
        end
        stub_busy = 1'b0;
      end
    end
  end

  task automatic run_test;
    logic [7:0] rx;
    logic r;
    logic [31:0] word;

    wait_clk(4);
    chk(start === 1'b0, "R9 start after reset", {31'b0, start}, 0);
    chk(miso === 1'b0, "R9 miso after reset", {31'b0, miso}, 0);
    rst_ni = 1'b1;
    wait_clk(4);

    // aborted window: 3 bits then deselect (R5)
    cs_on;
    spi_bit(1'b1, r); spi_bit(1'b0, r); spi_bit(1'b1, r);
    cs_off;
    chk(starts == 0, "R5 no start after partial byte", starts, 0);

    // one full frame with the engine enabled
    stub_en = 1'b1;
    cs_on;
    for (int i = 0; i < N; i++) begin
      exp_in.push_back(cplx(pat_b(i)));
      spi_byte(pat_b(i), rx);
      if (i == N-2) begin
        wait_clk(4);
        chk(starts == 0, "R3 no start before last byte", starts, 0);
      end
    end
    cs_off;
    wait(!stub_busy);
    wait_clk(4);
    chk(starts == 1, "R3 one start per frame", starts, 1);
    chk(start_hi == 1, "R3 start lasts one cycle", start_hi, 1);
    chk(exp_in.size() == 0, "R1 R5 all frame words read", exp_in.size(), 0);

    // idle line while deselected, sclk toggling (R8)
    for (int i = 0; i < 6; i++) begin
      sclk = ~sclk;
      wait_clk(3);
      chk(miso === 1'b0, "R8 miso idle", {31'b0, miso}, 0);
    end
    sclk = 1'b0;
    wait_clk(4);

    // four frames in, all results out in one window (R4, R6)
    stub_en = 1'b0;
    cs_on;
    for (int k = 0; k < N; k++) begin
      word = '0;
      for (int j = 0; j < 4; j++) begin
        spi_byte(8'((k*4 + j) * 11 + 3), rx);
        word = {word[23:0], rx};
      end
      begin
        logic [31:0] e;
        e = (exp_out.size() > 0) ? exp_out.pop_front() : 32'hDEAD_BEEF;
        chk(word === e, $sformatf("R6 return word %0d", k), word, e);
      end
    end
    cs_off;
    chk(starts == 5, "R4 starts after four more frames", starts, 5);

    // buffer holds last frame (bytes 48..63)
    for (int i = 0; i < N; i += 5) begin
      logic [31:0] e;
      e = cplx(8'((3*N + i) * 11 + 3));
      raddr = AW'(i);
      @(posedge clk);
      @(negedge clk);
      chk(rdata === e, $sformatf("R4 wrapped entry %0d", i), rdata, e);
    end

    // new window restarts at address 0, partial frame gives no start (R7)
    cs_on;
    for (int k = 0; k < 2; k++) begin
      word = '0;
      for (int j = 0; j < 4; j++) begin
        spi_byte(8'h11, rx);
        word = {word[23:0], rx};
      end
      chk(word === saved[k], $sformatf("R7 restart word %0d", k), word, saved[k]);
    end
    cs_off;
    chk(starts == 5, "R3 no start on partial frame", starts, 5);
    chk(miso === 1'b0, "R8 miso after window", {31'b0, miso}, 0);
  endtask

  initial begin
    fork
      run_test;
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule